// File: doc/BRIEF.md
# Self-Recovering Maximal-Length PN Generator

This block produces a pseudo-noise chip stream from a maximal-length linear feedback shift register. The stream serves data scrambling, direct-sequence spreading, or picking semi-random hop channels. By default the register has five stages and repeats every 31 chips. A parameter selects any width from 4 to 13, and each width takes its own feedback taps from a built-in table of maximal-length polynomials.

The feedback is an XNOR of the tapped stages. Under XNOR feedback the all-zeros word is an ordinary member of the cycle, and all-ones is the only lock-up word. The block watches for that lock-up word and, on the next enabled clock, clears the register to all zeros, which is the start of the period. Decoding all zeros gives an epoch strobe that marks each period boundary, for framing data or triggering a scope.

The block is fully static. A chip-enable input decides which clocks advance the sequence. While the enable is low the register holds its value for as long as the enable stays low.

Top module: `pn_gen`

## Requirements
- R1: With `rst` high at a rising clock edge, the register is loaded with all zeros, whatever the value of `chipEn`.
- R2: On an enabled clock from any state other than all ones, the register shifts towards the higher bit. The new bit 0 is the XNOR of the tapped stages: for the default width these are bit 4 and bit 1, i.e. stage five and stage two. `pnChip` always equals the top bit of `pnState`.
- R3: At the default width and starting from all zeros, 31 enabled clocks visit 31 distinct words, none of them all ones, and the register returns to all zeros on the 31st.
- R4: If the register holds all ones, the next enabled clock loads all zeros.
- R5: `epoch` is high exactly while `pnState` is all zeros. An enabled clock taken while `epoch` is high always lowers it on the next cycle.
- R6: While `chipEn` is low and `rst` is low, `pnState` does not change. This includes the all-ones word, which is held until an enabled clock.
- R7: The `WIDTH` parameter selects a maximal tap set. At width 4 the epoch recurs every 15 enabled clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; loads all zeros |
| chipEn | input | 1 | Advances the sequence by one chip when high |
| pnChip | output | 1 | Serial PN chip (top register bit) |
| pnState | output | WIDTH | Parallel register contents |
| epoch | output | 1 | High while the register holds the period-start word |

## Verification
The bench runs the sequence under a continuously high enable, and the result must match a tap-by-tap reference model; this exposes a wrong tap, a wrong polynomial or a wrong shift direction. It then runs the sequence with an irregular enable pattern, which separates a design that truly holds its state from one that drifts or skips a chip. The lock-up word is injected through a forced register value, first with the enable low (the word must be held) and then with it high (the word must clear), so a missing or premature recovery shows up. A full-period walk at width 5 and at width 4 checks the count of distinct words and the epoch spacing, which tells a maximal tap set apart from a short-cycling one.

// File: rtl/pn_gen_pkg.sv
package pn_gen_pkg;

  typedef struct packed {
    logic clearReg;  // load all zeros on this clock
    logic advance;   // shift one chip on this clock
  } pnStrobes_t;

  // Bit i set means stage i+1 feeds the XNOR; maximal taps for widths 4..13
  function automatic logic [15:0] tapMask(input int width);
    logic [15:0] m;
    case (width)
      4:       m = 16'h000C;
      5:       m = 16'h0012;
      6:       m = 16'h0030;
      7:       m = 16'h0060;
      8:       m = 16'h00B8;
      9:       m = 16'h0110;
      10:      m = 16'h0240;
      11:      m = 16'h0500;
      12:      m = 16'h0829;
      13:      m = 16'h100D;
      default: m = 16'h0012;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pn_gen_datapath.sv
module pn_gen_datapath
  import pn_gen_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  pnStrobes_t       strobes,
  output logic [WIDTH-1:0] stateQ,
  output logic             chip
);

  localparam logic [15:0]      TAP_FULL = tapMask(WIDTH);
  localparam logic [WIDTH-1:0] TAPS     = TAP_FULL[WIDTH-1:0];

  logic feedback;
  logic [WIDTH-1:0] shifted;

  always_comb begin
    feedback = ~(^(stateQ & TAPS));
    shifted  = {stateQ[WIDTH-2:0], feedback};
  end

  always_ff @(posedge clk) begin
    if (strobes.clearReg) begin
      stateQ <= '0;
    end else if (strobes.advance) begin
      stateQ <= shifted;
    end
  end

  assign chip = stateQ[WIDTH-1];

  // R2: an advance moves every bit one stage up
  a_r2_shift_up: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |=> stateQ[WIDTH-1:1] == $past(stateQ[WIDTH-2:0]));

  // R6: no strobe, no change
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!strobes.advance && !strobes.clearReg) |=> $stable(stateQ));

endmodule

// File: rtl/pn_gen_control.sv
module pn_gen_control
  import pn_gen_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chipEn,
  input  logic [WIDTH-1:0] stateQ,
  output pnStrobes_t       strobes,
  output logic             epoch
);

  logic allOnes;
  logic allZeros;

  always_comb begin
    allOnes          = &stateQ;
    allZeros         = ~|stateQ;
    strobes.clearReg = rst | (chipEn & allOnes);
    strobes.advance  = chipEn & ~rst & ~allOnes;
    epoch            = allZeros;
  end

  // R4: lock-up word clears on the next enabled clock
  a_r4_lockup_clears: assert property (@(posedge clk) disable iff (rst)
    (chipEn && allOnes) |=> (stateQ == '0));

  // R5: the epoch never lasts past an enabled clock
  a_r5_epoch_single: assert property (@(posedge clk) disable iff (rst)
    (epoch && chipEn) |=> !epoch);

  // R1: reset lands on the period-start word
  a_r1_reset_zero: assert property (@(posedge clk)
    ($past(rst) && rst) |-> (stateQ == '0));

endmodule

// File: rtl/pn_gen.sv
module pn_gen
  import pn_gen_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chipEn,
  output logic             pnChip,
  output logic [WIDTH-1:0] pnState,
  output logic             epoch
);

  if (WIDTH < 4 || WIDTH > 13) begin : g_badWidth
    $error("pn_gen: WIDTH must lie in 4..13");
  end

  pnStrobes_t strobes;
  logic [WIDTH-1:0] stateQ;

  pn_gen_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .chipEn  (chipEn),
    .stateQ  (stateQ),
    .strobes (strobes),
    .epoch   (epoch)
  );

  pn_gen_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .stateQ  (stateQ),
    .chip    (pnChip)
  );

  assign pnState = stateQ;

endmodule

// File: tb/test_pn_gen.sv
`timescale 1ns/1ps
module test_pn_gen;

  localparam int W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic chipEn = 1'b0;
  logic pnChip, epoch, pnChip4, epoch4;
  logic [W-1:0] pnState;
  logic [3:0] pnState4;

  pn_gen #(.WIDTH(W)) i_pn_gen (
    .clk(clk), .rst(rst), .chipEn(chipEn),
    .pnChip(pnChip), .pnState(pnState), .epoch(epoch));

  pn_gen #(.WIDTH(4)) i_pn_gen_w4 (
    .clk(clk), .rst(rst), .chipEn(chipEn),
    .pnChip(pnChip4), .pnState(pnState4), .epoch(epoch4));

  int checks = 0;
  int fails = 0;
  logic [W-1:0] expQ[$];
  string tagQ[$];
  logic [W-1:0] model = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Driver: applies inputs at the falling edge and queues the expected word
  task automatic step(input logic r, input logic en, input string tag);
    @(negedge clk);
    rst = r;
    chipEn = en;
    if (r) model = '0;                                   // R1
    else if (en) begin
      if (&model) model = '0;                            // R4
      else model = {model[W-2:0], ~(model[4] ^ model[1])}; // R2
    end
    expQ.push_back(model);
    tagQ.push_back(tag);
  endtask

  // Inject the lock-up word under reset, then release with the enable low
  task automatic injectStuck();
    @(negedge clk);
    rst = 1'b1;
    chipEn = 1'b0;
    force i_pn_gen.u_dp.stateQ = '1;
    model = '1;
    expQ.push_back(model);
    tagQ.push_back("R4");
    @(negedge clk);
    release i_pn_gen.u_dp.stateQ;
    rst = 1'b0;
    expQ.push_back(model);   // R6: all ones held while disabled
    tagQ.push_back("R6");
  endtask

  // Monitor: a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(pnState == e, t, "pnState", int'(pnState), int'(e));
        check(pnChip == e[W-1], "R2", "pnChip", int'(pnChip), int'(e[W-1]));
        check(epoch == (e == '0), "R5", "epoch", int'(epoch), int'(e == '0));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, "R2");
    for (int i = 0; i < 24; i++) step(1'b0, (i % 3) != 1, "R6");
    injectStuck();
    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, "R4");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R2");
    injectStuck();
    step(1'b1, 1'b0, "R1");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R2");
    wait (expQ.size() == 0);
    @(posedge clk);
    #6;

    // Full-period walk at both widths
    @(negedge clk);
    rst = 1'b1;
    chipEn = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    begin
      logic [31:0] seen;
      int distinct;
      int firstZero;
      seen = '0;
      distinct = 0;
      firstZero = 0;
      for (int k = 1; k <= 31; k++) begin
        @(posedge clk);
        #5;
        if (!seen[pnState]) distinct++;
        seen[pnState] = 1'b1;
        if (pnState == '0 && firstZero == 0) firstZero = k;
        check(epoch4 == ((k % 15) == 0), "R7", "width-4 epoch",
              int'(epoch4), int'((k % 15) == 0));
      end
      check(distinct == 31, "R3", "distinct words", distinct, 31);
      check(!seen[31], "R3", "all-ones visited", int'(seen[31]), 0);
      check(firstZero == 31, "R3", "period", firstZero, 31);
    end
    summary();
  end

endmodule